// File: doc/BRIEF.md
# Successive-Approximation Frequency Lock for a Current Trim Code

This block calibrates a current-starved oscillator by choosing an 8-bit binary-weighted scaling code for the current that feeds it. Several bits of the code can be set at once. The code with only its top bit set means the full mirrored current. Each lower bit adds a smaller fraction: half, a quarter, and so on. The block works by successive approximation. It starts at the most significant bit and tries one bit per step. For each trial it waits for the oscillator to settle. It then counts oscillator rising edges over a fixed window of reference-clock cycles and compares the count with a target. If the count is above the target, the trial bit is cleared. Otherwise the bit is kept.

The calibration sequence has a fixed order. First, the oscillator drive strength is chosen while the trim sits at the full-current code. The drive strength is a one-hot 4-bit code. Scaling starts only when a start request arrives with a legal drive code, and that code is then latched for the whole run. A request that carries an illegal drive code is refused with an error flag. The lock is coarse by design: the final code is the largest code whose measured count does not exceed the target. The oscillator input is asynchronous, so it is resynchronised to the reference clock before its edges are counted.

Top module: `sar_freq_lock`

## Requirements
- R1: After reset the trim output is the full-current code (only the top bit set, 0x80 for 8 bits), the drive-select output is 4'b0001, and done and err are 0.
- R2: A start request taken while idle, with a drive code that has exactly one bit set, copies that code to the drive-select output and clears err. The drive-select output always has exactly one bit set.
- R3: A start request taken while idle with a drive code of zero or more than one set bit sets err and starts nothing. Trim, done and drive-select keep their values.
- R4: The trial bits are resolved from the top bit down to bit 0. The first trial after an accepted start is the full-current code. Each later trial adds the next lower bit to the bits already decided. While a calibration runs, the trim output is never zero.
- R5: For each trial, the block waits SETTLE reference cycles. It then counts oscillator rising edges over WIN_CYC reference cycles. The trial bit is cleared if the count is greater than target_cnt and kept otherwise.
- R6: After the bit-0 decision, done is set and trim holds the result. For an oscillator whose rate rises monotonically with the code, the result is the largest code whose count does not exceed target_cnt, or zero if no code qualifies.
- R7: While idle and without a start request, trim, done and drive-select hold their values. A start request that arrives during a calibration is ignored.
- R8: An accepted start clears done in the next cycle and begins the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the windows and all registers |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | One-cycle request to begin a calibration |
| osc_clk | input | 1 | Oscillator output, asynchronous to clk |
| drv_code | input | DRV_W | Drive-strength code to be latched at start, must be one-hot |
| target_cnt | input | CNT_W | Highest acceptable edge count per window |
| trim | output | TRIM_W | Binary-weighted current scaling code |
| drv_sel | output | DRV_W | Latched one-hot drive-strength selection |
| done | output | 1 | Calibration finished, trim holds the result |
| err | output | 1 | Last start request carried an illegal drive code |

## Verification
The bench builds the block with a 256-cycle window and a 4-cycle settle time, so a full 8-step calibration takes about two thousand cycles. This makes a sweep over many targets affordable. The oscillator model is a phase accumulator whose increment is (code>>3)+32. A 256-cycle window then holds exactly that many edges, whatever the starting phase. The expected result is the largest qualifying code, found by a search in the bench. Sweeping the target from 28 to 66 covers three cases: no code qualifies, intermediate codes, and every code qualifies. It also exercises each keep-or-clear decision at each bit position.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_COUNT} meas_st_t;
  typedef enum logic {S_IDLE, S_MEAS} sar_st_t;
endpackage

// File: rtl/sfl_edge_sync.sv
module sfl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  // newest synchronised sample high, the one before it low
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sfl_win_meter.sv
module sfl_win_meter
  import sfl_pkg::*;
#(
  parameter int WIN_CYC = 1024,
  parameter int SETTLE  = 8,
  parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             rise,
  input  logic [CNT_W-1:0] target,
  output logic             done_p,
  output logic             over
);
  localparam int LONGEST = (WIN_CYC > SETTLE) ? WIN_CYC : SETTLE;
  localparam int TMR_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meas_st_t         st;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] ecnt;
  logic [CNT_W-1:0] ecnt_nx;

  always_comb begin
    ecnt_nx = ecnt;
    if (rise && ecnt != CNT_MAX) ecnt_nx = ecnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= M_IDLE;
      tmr    <= '0;
      ecnt   <= '0;
      done_p <= 1'b0;
      over   <= 1'b0;
    end else begin
      done_p <= 1'b0;
      case (st)
        M_IDLE: begin
          if (go) begin
            st   <= M_SETTLE;
            tmr  <= TMR_W'(SETTLE - 1);
            ecnt <= '0;
          end
        end
        M_SETTLE: begin
          if (tmr == '0) begin
            st  <= M_COUNT;
            tmr <= TMR_W'(WIN_CYC - 1);
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        M_COUNT: begin
          ecnt <= ecnt_nx;
          if (tmr == '0) begin
            st     <= M_IDLE;
            done_p <= 1'b1;
            over   <= (ecnt_nx > target);
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfl_sar_core.sv
module sfl_sar_core
  import sfl_pkg::*;
#(
  parameter int TRIM_W = 8,
  parameter int DRV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic [DRV_W-1:0]  drv_code,
  input  logic              meas_done,
  input  logic              meas_over,
  output logic              meas_go,
  output logic [TRIM_W-1:0] trim,
  output logic [DRV_W-1:0]  drv_sel,
  output logic              done,
  output logic              err,
  output logic              busy
);
  localparam int PTR_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
  localparam logic [TRIM_W-1:0] FULL_CODE = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [PTR_W-1:0]  TOP_PTR   = PTR_W'(TRIM_W - 1);

  sar_st_t           st;
  logic [PTR_W-1:0]  ptr;
  logic [TRIM_W-1:0] kept;
  logic              code_ok;

  assign code_ok = (drv_code != '0) && ((drv_code & (drv_code - DRV_W'(1))) == '0);
  assign kept    = meas_over ? (trim & ~(TRIM_W'(1) << ptr)) : trim;
  assign busy    = (st == S_MEAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ptr     <= TOP_PTR;
      trim    <= FULL_CODE;
      drv_sel <= DRV_W'(1);
      done    <= 1'b0;
      err     <= 1'b0;
      meas_go <= 1'b0;
    end else begin
      meas_go <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cal_start) begin
            if (code_ok) begin
              drv_sel <= drv_code;
              err     <= 1'b0;
              done    <= 1'b0;
              trim    <= FULL_CODE;
              ptr     <= TOP_PTR;
              meas_go <= 1'b1;
              st      <= S_MEAS;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_MEAS: begin
          if (meas_done) begin
            if (ptr == '0) begin
              trim <= kept;
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              trim    <= kept | (TRIM_W'(1) << (ptr - PTR_W'(1)));
              ptr     <= ptr - PTR_W'(1);
              meas_go <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_freq_lock.sv
module sar_freq_lock #(
  parameter int TRIM_W      = 8,
  parameter int DRV_W       = 4,
  parameter int WIN_CYC     = 1024,
  parameter int SETTLE      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic              osc_clk,
  input  logic [DRV_W-1:0]  drv_code,
  input  logic [CNT_W-1:0]  target_cnt,
  output logic [TRIM_W-1:0] trim,
  output logic [DRV_W-1:0]  drv_sel,
  output logic              done,
  output logic              err
);
  logic osc_rise;
  logic meas_go;
  logic meas_done;
  logic meas_over;
  logic busy;

  sfl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (osc_clk),
    .rise     (osc_rise)
  );

  sfl_win_meter #(.WIN_CYC(WIN_CYC), .SETTLE(SETTLE), .CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .go     (meas_go),
    .rise   (osc_rise),
    .target (target_cnt),
    .done_p (meas_done),
    .over   (meas_over)
  );

  sfl_sar_core #(.TRIM_W(TRIM_W), .DRV_W(DRV_W)) u_sar (
    .clk       (clk),
    .rst       (rst),
    .cal_start (cal_start),
    .drv_code  (drv_code),
    .meas_done (meas_done),
    .meas_over (meas_over),
    .meas_go   (meas_go),
    .trim      (trim),
    .drv_sel   (drv_sel),
    .done      (done),
    .err       (err),
    .busy      (busy)
  );
endmodule

// File: rtl/sfl_lock_chk.sv
module sfl_lock_chk #(
  parameter int TRIM_W = 8,
  parameter int DRV_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_start,
  input logic [DRV_W-1:0]  drv_code,
  input logic [TRIM_W-1:0] trim,
  input logic [DRV_W-1:0]  drv_sel,
  input logic              done,
  input logic              err,
  input logic              busy
);
  // R2
  drv_sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(drv_sel));

  // R3
  bad_drv_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_start && !busy && !$onehot(drv_code)) |=>
      (err && !busy && $stable(trim) && $stable(drv_sel) && $stable(done)));

  // R8
  good_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_start && !busy && $onehot(drv_code)) |=>
      (busy && !done && !err && drv_sel == $past(drv_code)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cal_start) |=> ($stable(trim) && $stable(done) && $stable(drv_sel)));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cal_start) |=> $stable(drv_sel));

  // R4
  trial_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (trim != '0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind sar_freq_lock sfl_lock_chk #(.TRIM_W(TRIM_W), .DRV_W(DRV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cal_start (cal_start),
  .drv_code  (drv_code),
  .trim      (trim),
  .drv_sel   (drv_sel),
  .done      (done),
  .err       (err),
  .busy      (busy)
);

// File: tb/sar_freq_lock_tb.sv
module sar_freq_lock_tb;
  localparam int TRIM_W = 8;
  localparam int DRV_W  = 4;
  localparam int WIN    = 256;
  localparam int CNT_W  = $clog2(WIN + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cal_start = 1'b0;
  logic              osc_clk;
  logic [DRV_W-1:0]  drv_code = 4'b0001;
  logic [CNT_W-1:0]  target_cnt = '0;
  logic [TRIM_W-1:0] trim;
  logic [DRV_W-1:0]  drv_sel;
  logic              done;
  logic              err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // oscillator model: 8-bit phase accumulator, increment (code>>3)+32
  logic [7:0] acc;
  logic [7:0] inc;
  assign inc = 8'({3'b0, trim[TRIM_W-1:3]}) + 8'd32;
  always @(negedge clk) begin
    if (rst) acc <= 8'd0;
    else     acc <= acc + inc;
  end
  assign osc_clk = acc[7];

  sar_freq_lock #(
    .TRIM_W(TRIM_W), .DRV_W(DRV_W), .WIN_CYC(WIN), .SETTLE(4),
    .SYNC_STAGES(2), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .osc_clk(osc_clk),
    .drv_code(drv_code), .target_cnt(target_cnt), .trim(trim),
    .drv_sel(drv_sel), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [DRV_W-1:0] code);
    @(negedge clk);
    drv_code  = code;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R6 done reached", int'(done), 1);
  endtask

  function automatic int expected_code(input int t);
    int e = 0;
    for (int c = 0; c < 256; c++)
      if (((c >> 3) + 32) <= t) e = c;
    return e;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TRIM_W-1:0] held;
    logic [DRV_W-1:0]  dheld;
    int tgt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(trim == 8'h80, "R1 trim", int'(trim), 8'h80);
    chk(drv_sel == 4'b0001, "R1 drv_sel", int'(drv_sel), 1);
    chk(done == 1'b0 && err == 1'b0, "R1 flags", int'({done, err}), 0);

    // R3 zero drive code refused
    pulse_start(4'b0000);
    chk(err == 1'b1, "R3 err on zero code", int'(err), 1);
    chk(trim == 8'h80 && done == 1'b0, "R3 nothing started", int'(trim), 8'h80);
    chk(drv_sel == 4'b0001, "R3 drv kept", int'(drv_sel), 1);

    // R2 R8 R4 good start
    target_cnt = CNT_W'(40);
    pulse_start(4'b0100);
    chk(drv_sel == 4'b0100, "R2 drv latched", int'(drv_sel), 4);
    chk(err == 1'b0, "R2 err cleared", int'(err), 0);
    chk(trim == 8'h80, "R4 first trial full code", int'(trim), 8'h80);
    chk(done == 1'b0, "R8 done low", int'(done), 0);

    // R7 start during run ignored
    repeat (100) @(negedge clk);
    pulse_start(4'b0010);
    chk(drv_sel == 4'b0100, "R7 busy start ignored", int'(drv_sel), 4);
    wait_done();
    chk(trim == 8'(expected_code(40)), "R6 result t=40", int'(trim), expected_code(40));

    // R7 hold while idle
    held = trim;
    repeat (50) @(negedge clk);
    chk(trim == held && done == 1'b1, "R7 hold idle", int'(trim), int'(held));

    // R3 multi-bit code refused after a result
    dheld = drv_sel;
    pulse_start(4'b0110);
    chk(err == 1'b1, "R3 err on multi-bit code", int'(err), 1);
    chk(trim == held && done == 1'b1 && drv_sel == dheld, "R3 state kept",
        int'(trim), int'(held));

    // R5 R6 sweep of targets across none, partial and all codes
    for (int t = 28; t <= 66; t++) begin
      logic [DRV_W-1:0] dc;
      dc = DRV_W'(1) << (t % DRV_W);
      target_cnt = CNT_W'(t);
      pulse_start(dc);
      chk(done == 1'b0 && err == 1'b0, "R8 start clears flags", int'({done, err}), 0);
      wait_done();
      tgt = expected_code(t);
      chk(trim == 8'(tgt), $sformatf("R5 R6 result t=%0d", t), int'(trim), tgt);
      chk(drv_sel == dc, "R2 drv during sweep", int'(drv_sel), int'(dc));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule